// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block looks at the first six bytes of each received frame, which form the 48-bit destination address, and decides whether the frame is for this station. A unicast address is compared with a programmed station address. The all-ones broadcast address is taken when broadcast reception is enabled. Any other group address is hashed: a CRC-32 runs over the address bytes as they arrive, and six of its bits select one bit of a 64-bit table. A promiscuous mode takes every frame. A monitor mode still reaches the same verdict but marks the frame as not to be stored and flags it as missed.

The station address and the hash table sit in a byte-wide register file written through one write port. The receive mode is a byte-wide configuration input. Bytes enter one per cycle when `rx_valid` is high, and `rx_sof` marks the first byte of a frame. The verdict appears as a single-cycle `dec_valid` pulse together with its result flags. Bytes past the sixth are ignored until the next start of frame. Checking the CRC of the whole frame is left to other logic.

Top module: `addr_filter`

## Requirements
- R1: After reset `dec_valid` is low, and every station address byte and hash table byte reads as zero. A group address with hashing enabled is therefore rejected until the table is written.
- R2: `dec_valid` is high for exactly one cycle, in the cycle after the sixth address byte is taken. Bytes after the sixth do not raise it again until a new `rx_sof`.
- R3: An address whose first byte has bit 0 clear is accepted only if all six bytes equal the station address. Byte i on the wire (i = 0 first) is compared with register select i (0..5). The first byte carries bits 7:0 of the address.
- R4: The all-ones address is accepted exactly when `rx_mode` bit 2 is set, or when promiscuous mode is on.
- R5: A group address (first byte bit 0 set) other than all-ones is accepted when `rx_mode` bit 3 is set and the selected table bit is set.
  - The running CRC starts at all ones and handles each byte LSB first with the reflected polynomial 0xEDB88320, with no final inversion.
  - Its low six bits, reversed in order, give index k.
  - Bit k%8 of the table byte at register select 6 + k/8 is the selected bit.
- R6: With `rx_mode` bit 4 set, every frame is accepted.
- R7: `dec_group` equals bit 0 of the first address byte.
- R8: With `rx_mode` bit 5 (monitor) set, `dec_store` is low and `dec_monitor_miss` equals `dec_accept`. Otherwise `dec_store` equals `dec_accept` and `dec_monitor_miss` is low.
- R9: Cycles with `rx_valid` low are stalls. They neither count as address bytes nor change the verdict.
- R10: An `rx_sof` in the middle of an address drops the partial address and starts a new one with that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select: 0..5 station bytes, 6..13 hash table bytes |
| cfg_wdata | input | 8 | Register write data |
| rx_mode | input | 8 | Mode: bit 2 broadcast, bit 3 hashed group, bit 4 promiscuous, bit 5 monitor |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of a frame (with rx_valid) |
| rx_data | input | 8 | Received byte |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_store | output | 1 | Frame accepted and to be stored |
| dec_group | output | 1 | Destination is a group address |
| dec_monitor_miss | output | 1 | Accepted while in monitor mode (counts as missed) |

## Verification
The verdict comes from one register stage: the sixth byte is taken at a rising edge, and `dec_valid` and its flags are readable until the next rising edge. The bench drives each byte on a falling edge and samples the verdict on the falling edge that follows the edge taking the sixth byte. It samples once more one cycle later to confirm the pulse has ended. Stall cycles between bytes shift that point by exactly the number of stalls. The bench also checks every falling edge during trailing bytes to confirm that no second pulse appears.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;

    localparam int ADDR_BYTES  = 6;
    localparam int ADDR_W      = ADDR_BYTES * 8;
    localparam int HASH_W      = 6;
    localparam int TABLE_BITS  = 1 << HASH_W;
    localparam int TABLE_BYTES = TABLE_BITS / 8;
    localparam int NUM_REGS    = ADDR_BYTES + TABLE_BYTES;
    localparam int SEL_W       = $clog2(NUM_REGS);
    localparam int CNT_W       = $clog2(ADDR_BYTES + 1);

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

    // rx_mode bit positions
    localparam int MODE_BCAST   = 2;
    localparam int MODE_GROUP   = 3;
    localparam int MODE_PROMISC = 4;
    localparam int MODE_MONITOR = 5;

    typedef struct packed {
        logic valid;
        logic accept;
        logic store;
        logic group;
        logic monitor_miss;
    } verdict_t;

    // one byte through the reflected CRC-32, LSB first
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [HASH_W-1:0] hash_index(input logic [31:0] c);
        logic [HASH_W-1:0] r;
        for (int i = 0; i < HASH_W; i++) r[i] = c[HASH_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/addr_filter_regs.sv
module addr_filter_regs
    import addr_filter_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [SEL_W-1:0]      sel,
    input  logic [7:0]            wdata,
    output logic [ADDR_W-1:0]     station,
    output logic [TABLE_BITS-1:0] table_bits
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)                                   q <= '0;
            else if (we && sel == SEL_W'(g))           q <= wdata;
        end
        if (g < ADDR_BYTES) begin : g_sta
            assign station[g*8 +: 8] = q;
        end else begin : g_tbl
            assign table_bits[(g-ADDR_BYTES)*8 +: 8] = q;
        end
    end

endmodule

// File: rtl/addr_filter_capture.sv
module addr_filter_capture
    import addr_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_data,
    output logic [ADDR_W-1:0] addr,
    output logic [31:0]       crc,
    output logic              done
);

    logic [CNT_W-1:0]           cnt_q;
    logic [ADDR_BYTES-1:0][7:0] addr_q;
    logic [31:0]                crc_q;
    logic                       done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            addr_q <= '0;
            crc_q  <= CRC_INIT;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (rx_valid) begin
                if (rx_sof) begin
                    addr_q[0] <= rx_data;
                    crc_q     <= crc_step(CRC_INIT, rx_data);
                    cnt_q     <= CNT_W'(1);
                    done_q    <= (ADDR_BYTES == 1);
                end else if (cnt_q != '0 && cnt_q < CNT_W'(ADDR_BYTES)) begin
                    addr_q[cnt_q] <= rx_data;
                    crc_q         <= crc_step(crc_q, rx_data);
                    cnt_q         <= cnt_q + CNT_W'(1);
                    done_q        <= (cnt_q == CNT_W'(ADDR_BYTES - 1));
                end
            end
        end
    end

    assign addr = addr_q;
    assign crc  = crc_q;
    assign done = done_q;

endmodule

// File: rtl/addr_filter_decide.sv
module addr_filter_decide
    import addr_filter_pkg::*;
(
    input  logic                  done,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           crc,
    input  logic [ADDR_W-1:0]     station,
    input  logic [TABLE_BITS-1:0] table_bits,
    input  logic [7:0]            mode,
    output verdict_t              verdict
);

    logic              is_group, is_bcast, uni_hit, tbl_hit, take;
    logic [HASH_W-1:0] idx;

    always_comb begin
        is_group = addr[0];
        is_bcast = &addr;
        uni_hit  = (addr == station);
        idx      = hash_index(crc);
        tbl_hit  = table_bits[idx];

        if (mode[MODE_PROMISC]) take = 1'b1;
        else if (is_bcast)      take = mode[MODE_BCAST];
        else if (is_group)      take = mode[MODE_GROUP] & tbl_hit;
        else                    take = uni_hit;

        verdict.valid        = done;
        verdict.accept       = done & take;
        verdict.group        = done & is_group;
        verdict.store        = done & take & ~mode[MODE_MONITOR];
        verdict.monitor_miss = done & take &  mode[MODE_MONITOR];
    end

endmodule

// File: rtl/addr_filter.sv
module addr_filter
    import addr_filter_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic [7:0]       rx_mode,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [7:0]       rx_data,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_store,
    output logic             dec_group,
    output logic             dec_monitor_miss
);

    logic [ADDR_W-1:0]     station, addr;
    logic [TABLE_BITS-1:0] table_bits;
    logic [31:0]           crc;
    logic                  done;
    verdict_t              verdict;

    addr_filter_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .station(station), .table_bits(table_bits)
    );

    addr_filter_capture u_cap (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .addr(addr), .crc(crc), .done(done)
    );

    addr_filter_decide u_dec (
        .done(done), .addr(addr), .crc(crc), .station(station),
        .table_bits(table_bits), .mode(rx_mode), .verdict(verdict)
    );

    assign dec_valid        = verdict.valid;
    assign dec_accept       = verdict.accept;
    assign dec_store        = verdict.store;
    assign dec_group        = verdict.group;
    assign dec_monitor_miss = verdict.monitor_miss;

endmodule

// File: rtl/addr_filter_checker.sv
module addr_filter_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic [7:0] rx_mode,
    input logic       dec_valid,
    input logic       dec_accept,
    input logic       dec_store,
    input logic       dec_monitor_miss
);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    assert_byte_before_verdict_R9: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(rx_valid));

    assert_promisc_takes_all_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && rx_mode[4]) |-> dec_accept);

    assert_monitor_no_store_R8: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && rx_mode[5]) |-> (!dec_store && dec_monitor_miss == dec_accept));

    assert_normal_store_R8: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !rx_mode[5]) |-> (dec_store == dec_accept && !dec_monitor_miss));

endmodule

bind addr_filter addr_filter_checker u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_mode(rx_mode),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_store(dec_store),
    .dec_monitor_miss(dec_monitor_miss)
);

// File: tb/addr_filter_bench.sv
module addr_filter_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] rx_mode = '0;
    logic       rx_valid = 1'b0;
    logic       rx_sof = 1'b0;
    logic [7:0] rx_data = '0;
    logic       dec_valid, dec_accept, dec_store, dec_group, dec_monitor_miss;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [47:0] st_model = '0;
    logic [63:0] tbl_model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_filter u_addr_filter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rx_mode(rx_mode), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_store(dec_store),
        .dec_group(dec_group), .dec_monitor_miss(dec_monitor_miss)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] model_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        logic fb;
        logic [5:0] k;
        for (int b = 0; b < 48; b++) begin
            fb = c[0] ^ a[b];
            c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
        end
        for (int i = 0; i < 6; i++) k[5-i] = c[i];
        return k;
    endfunction

    function automatic bit model_accept(input logic [47:0] a, input logic [7:0] m);
        if (m[4]) return 1;
        if (a == 48'hFFFF_FFFF_FFFF) return m[2];
        if (a[0]) return m[3] && tbl_model[model_index(a)];
        return a == st_model;
    endfunction

    task automatic wr_reg(input int sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 6) st_model[sel*8 +: 8] = d;
        else         tbl_model[(sel-6)*8 +: 8] = d;
    endtask

    // ends at the falling edge just after the sixth byte is taken
    task automatic send_addr(input logic [47:0] a, input int gap);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_data = a[i*8 +: 8];
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    rx_valid = 1'b0; rx_sof = 1'b0; rx_data = 8'h3C;
                    if (dec_valid !== 1'b0) check("R9", "early verdict during stall", dec_valid, 0);
                end
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
    endtask

    task automatic expect_verdict(input string req, input logic [47:0] a);
        bit acc;
        acc = model_accept(a, rx_mode);
        check(req, "dec_valid", dec_valid, 1);
        check(req, "dec_accept", dec_accept, acc);
        check("R8", "dec_store", dec_store, acc && !rx_mode[5]);
        check("R8", "dec_monitor_miss", dec_monitor_miss, acc && rx_mode[5]);
        check("R7", "dec_group", dec_group, a[0]);
        @(negedge clk);
        check("R2", "pulse ended", dec_valid, 0);
    endtask

    task automatic t_reset;
        logic [47:0] g = {8'h01, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
        check("R1", "dec_valid after reset", dec_valid, 0);
        rx_mode = 8'h08;
        send_addr(g, 0);
        check("R1", "group rejected with cleared table", dec_accept, 0);
        @(negedge clk);
        send_addr(48'h0, 0);
        check("R1", "zero station matches zero unicast", dec_accept, 1);
        @(negedge clk);
    endtask

    task automatic t_unicast;
        logic [47:0] me = 48'h5544_3322_1102;
        for (int i = 0; i < 6; i++) wr_reg(i, me[i*8 +: 8]);
        rx_mode = 8'h04;
        send_addr(me, 0);
        expect_verdict("R3", me);
        send_addr(me ^ 48'h0100_0000_0000, 0);
        expect_verdict("R3", me ^ 48'h0100_0000_0000);
        check("R3", "last-byte mismatch rejected", model_accept(me ^ 48'h0100_0000_0000, rx_mode), 0);
    endtask

    task automatic t_broadcast;
        rx_mode = 8'h04;
        send_addr(48'hFFFF_FFFF_FFFF, 0);
        expect_verdict("R4", 48'hFFFF_FFFF_FFFF);
        rx_mode = 8'h08;
        wr_reg(6 + model_index(48'hFFFF_FFFF_FFFF) / 8, 8'hFF);
        send_addr(48'hFFFF_FFFF_FFFF, 0);
        check("R4", "broadcast rejected when disabled", dec_accept, 0);
        @(negedge clk);
        for (int i = 6; i < 14; i++) wr_reg(i, 8'h00);
    endtask

    task automatic t_hash;
        logic [47:0] g1 = {8'h01, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
        logic [47:0] g2 = {8'hFB, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
        logic [5:0]  k  = model_index(g1);
        rx_mode = 8'h08;
        wr_reg(6 + k / 8, 8'(1 << (k % 8)));
        send_addr(g1, 0);
        check("R5", "hashed group accepted", dec_accept, 1);
        @(negedge clk);
        send_addr(g2, 0);
        expect_verdict("R5", g2);
        rx_mode = 8'h00;
        send_addr(g1, 0);
        check("R5", "group rejected when hashing disabled", dec_accept, 0);
        @(negedge clk);
        wr_reg(6 + k / 8, 8'(~(1 << (k % 8))));
        rx_mode = 8'h08;
        send_addr(g1, 0);
        check("R5", "other table bits do not accept", dec_accept, 0);
        @(negedge clk);
    endtask

    task automatic t_promisc;
        rx_mode = 8'h10;
        send_addr(48'h0123_4567_89AC, 0);
        check("R6", "foreign unicast accepted", dec_accept, 1);
        @(negedge clk);
        send_addr(48'hFFFF_FFFF_FFFF, 0);
        check("R6", "broadcast accepted with bit2 clear", dec_accept, 1);
        @(negedge clk);
    endtask

    task automatic t_monitor;
        rx_mode = 8'h24;
        send_addr(st_model, 0);
        expect_verdict("R8", st_model);
        rx_mode = 8'h20;
        send_addr(48'h0123_4567_89AC, 0);
        expect_verdict("R8", 48'h0123_4567_89AC);
    endtask

    task automatic t_timing;
        rx_mode = 8'h04;
        send_addr(st_model, 3);
        expect_verdict("R9", st_model);
        for (int i = 0; i < 10; i++) begin
            rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'hA5;
            @(negedge clk);
            if (i == 9) check("R2", "no verdict on trailing bytes", dec_valid, 0);
            else if (dec_valid !== 1'b0) check("R2", "trailing verdict", dec_valid, 0);
        end
        rx_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_data = 8'h40 + 8'(i);
        end
        send_addr(st_model, 0);
        expect_verdict("R10", st_model);
        check("R10", "restart uses new address", model_accept(st_model, rx_mode), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_broadcast();
        t_hash();
        t_promisc();
        t_monitor();
        t_timing();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule